// File: doc/BRIEF.md
# Serial-bus byte memory slave

This block is the slave end of a four-wire serial memory link in clock mode 0, where the serial clock idles low. It never generates the serial clock. It has separate data-in and data-out wires, and the data-out wire comes with an enable so the pad can float it. It also has an active-low pause input.

All four bus inputs pass through a synchronizer into the system clock domain, and the block works on the detected edges. Each selection starts with one 8-bit command byte. The command decides what follows:

- a 16-bit address and then a stream of data bytes for array reads and writes;
- one byte read from or written to the status register;
- nothing, for the two commands that set or clear the write-permit latch.

The storage is a byte-wide array that the synthesis tool can map to block RAM. Writes collect in a small page buffer and reach the array only after the host deselects the block, so a transfer cut short in the middle of a byte leaves the array untouched.

The block has three protections. A pause on the active-low pause input freezes a transfer where it stands. An unknown command locks the interface until the next selection. Array and status writes take effect only after an explicit write-permit command.

Top module: `spi_mem_slave`

## Requirements
- R1: The first byte after chip select falls is the command, received MSB first. The command codes are: 0x06 set the write-permit latch, 0x04 clear it, 0x05 read status, 0x01 write status, 0x03 read the array, 0x02 write the array.
- R2: Input bits are taken on rising serial-clock edges and output bits change only on falling edges. Output bytes are sent MSB first, and the first output bit appears on the falling edge after the last command or address bit.
- R3: While chip select is high, the output enable is low and the data and clock inputs have no effect on any state.
- R4: The read command takes a 16-bit address, MSB byte first, of which only the low ADDR_W bits are used. It then streams bytes from that address, incrementing after each byte and wrapping at the end of the array, until deselect.
- R5: Write data bytes fill a page of 2**PAGE_W bytes, starting at the address's offset within the page and wrapping inside it. The page is copied into the array after chip select rises.
- R6: The write-permit latch is set by 0x06 and cleared by 0x04. It is also cleared when an array or status write takes effect. Write commands given while it is clear leave the array and the status unchanged.
- R7: The status byte has bit 0 busy, always 0; bit 1 the write-permit latch; bits 3:2 the protect field, the only bits a status write changes; and all other bits 0. A status read repeats the status byte for as long as clocking continues.
- R8: While the pause input is low, clock edges are ignored and the output enable is low. Once the pause ends, the transfer continues from the same bit.
- R9: After an unknown command, no more bits are taken, the output stays disabled, and later bytes in the same selection have no effect. The next falling edge of chip select restores normal operation.
- R10: After reset, the output enable and data output are low, the write-permit latch is clear and the protect field is 0.
- R11: If chip select rises during a partial byte of a write, nothing is committed and the write-permit latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for the data-out pad |

## Verification
Every bus pin reaches the logic after SYNC_STAGES clocks, and the output registers add one more clock. As a result, the data output moves three clocks after a falling serial-clock edge on the pin, and the page commit ends 2**PAGE_W clocks after that delay from chip select rising. The bench holds each serial-clock level for eight system clocks. It samples the data output at the end of the low level, as the clock rises, and samples it again at the end of the high level to confirm it did not move. It also waits sixteen clocks after each deselect before starting the next selection, so that every commit has finished.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;
  typedef enum logic [7:0] {
    OP_STAT_WRITE  = 8'h01,
    OP_ARRAY_WRITE = 8'h02,
    OP_ARRAY_READ  = 8'h03,
    OP_WR_DISABLE  = 8'h04,
    OP_STAT_READ   = 8'h05,
    OP_WR_ENABLE   = 8'h06
  } opcode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_SRD,
    ST_SWR,
    ST_DONE,
    ST_LOCK
  } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
`timescale 1ns/1ps
module spi_mem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_mem_ram.sv
`timescale 1ns/1ps
module spi_mem_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
`timescale 1ns/1ps
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  input  logic spi_hold_n,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  // synchronized pins: {cs_n, sck, si, hold_n}
  logic [3:0] pins_s;
  logic       s_cs, s_sck, s_si, s_hold;
  logic       cs_d, sck_d;

  spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sck, spi_si, spi_hold_n}),
    .q   (pins_s)
  );
  assign {s_cs, s_sck, s_si, s_hold} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= s_cs;
      sck_d <= s_sck;
    end
  end

  logic cs_fall, cs_rise, sck_rise, sck_fall, shift_ok;
  assign cs_fall  = cs_d & ~s_cs;
  assign cs_rise  = ~cs_d & s_cs;
  assign sck_rise = s_sck & ~sck_d;
  assign sck_fall = ~s_sck & sck_d;
  assign shift_ok = ~s_cs & s_hold;

  phase_e            st;
  logic [2:0]        bit_cnt;
  logic [7:0]        rx, tx, addr_hi, swr_val;
  logic              addr_byte, swr_got, cmd_wr, drive_en;
  logic              wlatch;
  logic [1:0]        prot;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] wp, cidx;
  logic [PAGE-1:0]   vld;
  logic              commit_busy;
  logic [7:0]        pbuf [PAGE];

  logic [7:0] rx_byte, status, rdata, src;
  logic       byte_done, pbuf_we, ram_we;

  assign rx_byte   = {rx[6:0], s_si};
  assign byte_done = shift_ok & sck_rise & (bit_cnt == 3'd7) & ~cs_fall & ~cs_rise;
  assign pbuf_we   = byte_done & (st == ST_WR);
  assign status    = {4'b0000, prot, wlatch, 1'b0};
  assign src       = (st == ST_RD) ? rdata : status;
  assign ram_we    = commit_busy & vld[cidx];

  spi_mem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr ({addr[ADDR_W-1 -: BASE_W], cidx}),
    .wdata (pbuf[cidx]),
    .raddr (addr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (pbuf_we) pbuf[wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      rx          <= '0;
      tx          <= '0;
      addr_hi     <= '0;
      swr_val     <= '0;
      addr_byte   <= 1'b0;
      swr_got     <= 1'b0;
      cmd_wr      <= 1'b0;
      drive_en    <= 1'b0;
      wlatch      <= 1'b0;
      prot        <= '0;
      addr        <= '0;
      wp          <= '0;
      cidx        <= '0;
      vld         <= '0;
      commit_busy <= 1'b0;
      spi_so      <= 1'b0;
      spi_so_oe   <= 1'b0;
    end else begin
      if (commit_busy) begin
        cidx <= cidx + PAGE_W'(1);
        if (cidx == PAGE_W'(PAGE-1)) commit_busy <= 1'b0;
      end

      spi_so_oe <= drive_en & shift_ok & ((st == ST_RD) || (st == ST_SRD));

      if (cs_fall) begin
        st        <= ST_OPC;
        bit_cnt   <= '0;
        drive_en  <= 1'b0;
        addr_byte <= 1'b0;
        swr_got   <= 1'b0;
      end else if (cs_rise) begin
        st       <= ST_IDLE;
        drive_en <= 1'b0;
        if (bit_cnt == 3'd0 && wlatch) begin
          if (st == ST_WR && |vld) begin
            commit_busy <= 1'b1;
            cidx        <= '0;
            wlatch      <= 1'b0;
          end
          if (st == ST_SWR && swr_got) begin
            prot   <= swr_val[3:2];
            wlatch <= 1'b0;
          end
        end
      end else if (shift_ok) begin
        if (sck_rise && st != ST_LOCK && st != ST_IDLE) begin
          rx      <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            unique case (st)
              ST_OPC: begin
                unique case (rx_byte)
                  OP_WR_ENABLE:   begin wlatch <= 1'b1; st <= ST_DONE; end
                  OP_WR_DISABLE:  begin wlatch <= 1'b0; st <= ST_DONE; end
                  OP_STAT_READ:   st <= ST_SRD;
                  OP_STAT_WRITE:  st <= ST_SWR;
                  OP_ARRAY_READ:  begin st <= ST_ADDR; cmd_wr <= 1'b0; end
                  OP_ARRAY_WRITE: begin st <= ST_ADDR; cmd_wr <= 1'b1; end
                  default:        st <= ST_LOCK;
                endcase
              end
              ST_ADDR: begin
                if (!addr_byte) begin
                  addr_hi   <= rx_byte;
                  addr_byte <= 1'b1;
                end else begin
                  addr <= ADDR_W'({addr_hi, rx_byte});
                  wp   <= rx_byte[PAGE_W-1:0];
                  vld  <= '0;
                  st   <= cmd_wr ? ST_WR : ST_RD;
                end
              end
              ST_RD: addr <= addr + ADDR_W'(1);
              ST_WR: begin
                vld[wp] <= 1'b1;
                wp      <= wp + PAGE_W'(1);
              end
              ST_SWR: begin
                swr_val <= rx_byte;
                swr_got <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        if (sck_fall && (st == ST_RD || st == ST_SRD)) begin
          if (bit_cnt == 3'd0) begin
            spi_so   <= src[7];
            tx       <= {src[6:0], 1'b0};
            drive_en <= 1'b1;
          end else begin
            spi_so <= tx[7];
            tx     <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave_chk.sv
`timescale 1ns/1ps
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_q,
  input logic       hold_q,
  input logic       in_lock,
  input logic       sck_rise,
  input logic       cs_fall,
  input logic [2:0] bit_cnt,
  input logic       wlatch,
  input logic       commit_busy,
  input logic       spi_so_oe
);
  a_r10_reset_quiet: assert property (@(posedge clk) rst |=> !spi_so_oe);

  a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !spi_so_oe);

  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    !hold_q |=> !spi_so_oe);

  a_r9_lock_quiet: assert property (@(posedge clk) disable iff (rst)
    in_lock |=> !spi_so_oe);

  a_r2_count_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!sck_rise && !cs_fall) |=> $stable(bit_cnt));

  a_r6_commit_clears_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_busy) |-> !wlatch);
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_q        (s_cs),
  .hold_q      (s_hold),
  .in_lock     (st == spi_mem_pkg::ST_LOCK),
  .sck_rise    (sck_rise),
  .cs_fall     (cs_fall),
  .bit_cnt     (bit_cnt),
  .wlatch      (wlatch),
  .commit_busy (commit_busy),
  .spi_so_oe   (spi_so_oe)
);

// File: tb/spi_mem_slave_bench.sv
`timescale 1ns/1ps
module spi_mem_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, oe;

  always #10 clk = ~clk;

  spi_mem_slave u_spi_mem_slave (
    .clk        (clk),
    .rst        (rst),
    .spi_cs_n   (cs_n),
    .spi_sck    (sck),
    .spi_si     (si),
    .spi_hold_n (hold_n),
    .spi_so     (so),
    .spi_so_oe  (oe)
  );

  int n_chk = 0, n_fail = 0, stab_err = 0;
  bit oe_any;
  logic [7:0] model [256];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r, input int hold_at = -1);
    r = '0;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) begin
        tick(H);
        hold_n = 1'b0;
        tick(H);
        repeat (2) begin sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
        check("R8 output released during pause", 32'(oe), 32'd0);
        hold_n = 1'b1;
      end
      si = d[i];
      tick(H);
      sck = 1'b1;
      r[i] = so;
      if (oe) oe_any = 1'b1;
      tick(H);
      if (oe && so !== r[i]) stab_err++;
      sck = 1'b0;
    end
  endtask

  task automatic xbits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = d[i];
      tick(H); sck = 1'b1; tick(H); sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0; tick(H);
  endtask

  task automatic cs_off();
    tick(H); cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_on(); xfer(op, r); cs_off();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    cs_on(); xfer(8'h05, r); xfer(8'h00, s); cs_off();
  endtask

  task automatic rd_byte(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] r;
    cs_on(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(8'h00, v); cs_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r, v;
    tick(5);
    rst = 1'b0;
    tick(4);
    check("R10 output enable after reset", 32'(oe), 32'd0);
    check("R10 data out after reset", 32'(so), 32'd0);
    rd_status(v);
    check("R10 R7 status after reset", 32'(v), 32'h00);

    cmd1(8'h06);
    rd_status(v);
    check("R1 R6 latch set shows in status bit 1", 32'(v), 32'h02);
    check("R7 status drives output", 32'(oe_any), 32'd1);
    cmd1(8'h04);
    rd_status(v);
    check("R6 latch cleared", 32'(v), 32'h00);

    // fill the whole array one page at a time
    for (int p = 0; p < 64; p++) begin
      cmd1(8'h06);
      cs_on();
      xfer(8'h02, r); xfer(8'h00, r); xfer(8'(p * 4), r);
      for (int k = 0; k < 4; k++) begin
        xfer(pat(p * 4 + k), r);
        model[p * 4 + k] = pat(p * 4 + k);
      end
      cs_off();
    end

    // one long read: upper address bits ignored, wraps past the last byte
    cs_on();
    xfer(8'h03, r); xfer(8'hAB, r); xfer(8'hFE, r);
    for (int k = 0; k < 258; k++) begin
      xfer(8'h00, v);
      check("R4 streamed read", 32'(v), 32'(model[(254 + k) & 255]));
    end
    cs_off();
    check("R2 output steady while clock high", 32'(stab_err), 32'd0);

    rd_status(v);
    check("R6 latch cleared by commit", 32'(v), 32'h00);

    cs_on(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h5A, r); cs_off();
    rd_byte(16'h0010, v);
    check("R6 array write without latch ignored", 32'(v), 32'(model[16]));
    cs_on(); xfer(8'h01, r); xfer(8'hFF, r); cs_off();
    rd_status(v);
    check("R6 status write without latch ignored", 32'(v), 32'h00);

    cmd1(8'h06);
    cs_on(); xfer(8'h01, r); xfer(8'hFF, r); cs_off();
    cs_on(); xfer(8'h05, r); xfer(8'h00, v); xfer(8'h00, r); cs_off();
    check("R7 only protect bits written", 32'(v), 32'h0C);
    check("R7 status repeats", 32'(r), 32'h0C);

    // page wrap: five bytes starting at offset 2 of page 0x40
    cmd1(8'h06);
    cs_on(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h42, r);
    for (int k = 0; k < 5; k++) begin
      xfer(8'hA1 + 8'(k), r);
      model[8'h40 + ((2 + k) % 4)] = 8'hA1 + 8'(k);
    end
    cs_off();
    cs_on(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h40, r);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, v);
      check("R5 page wrap write", 32'(v), 32'(model[8'h40 + k]));
    end
    cs_off();

    // deselect in the middle of a byte
    cmd1(8'h06);
    cs_on(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h20, r); xfer(8'h77, r); xbits(8'h99, 3); cs_off();
    rd_byte(16'h0020, v);
    check("R11 partial byte commits nothing", 32'(v), 32'(model[32]));
    rd_status(v);
    check("R11 latch kept after partial byte", 32'(v), 32'h0E);
    cmd1(8'h04);
    rd_status(v);
    check("R6 latch cleared by disable", 32'(v), 32'h0C);

    // unknown command locks the interface
    cs_on();
    xfer(8'hFF, r);
    xfer(8'h06, r);
    check("R9 no output after unknown command", 32'(oe_any), 32'd0);
    xfer(8'h05, r);
    check("R9 still no output", 32'(oe_any), 32'd0);
    cs_off();
    rd_status(v);
    check("R9 locked bytes ignored, interface restored", 32'(v), 32'h0C);

    // pause in the address and in a data byte
    cs_on(); xfer(8'h03, r); xfer(8'h00, r, 3); xfer(8'h40, r);
    xfer(8'h00, v, 4);
    check("R8 byte intact across pause", 32'(v), 32'(model[8'h40]));
    xfer(8'h00, v);
    check("R8 stream continues after pause", 32'(v), 32'(model[8'h41]));
    cs_off();

    // deselected: clock a latch-set pattern, nothing happens
    for (int i = 7; i >= 0; i--) begin
      si = (8'h06 >> i) & 1;
      tick(H); sck = 1'b1; tick(H);
      if (oe) oe_any = 1'b1;
      sck = 1'b0;
    end
    check("R3 output disabled while deselected", 32'(oe), 32'd0);
    tick(H);
    rd_status(v);
    check("R3 deselected bits ignored", 32'(v), 32'h0C);

    finish_run();
  end
endmodule